// File: doc/BRIEF.md
# PECI bit transmit encoder

This block turns a stream of message bytes into the single-wire PECI transmit waveform. Every bit occupies one fixed bit period measured in system clocks. The period opens with a rising edge. The line stays high for a long fraction of the period to send a one, or a short fraction to send a zero, and is driven low for the rest. Bytes go out most significant bit first. The bytes of a message follow each other with no gap between bits.

A message begins when `start_i` and `byte_valid_i` are both high while the encoder is idle. The bit period on `bit_period_i` is captured at that moment and holds for the whole message, so the bit time cannot drift inside a frame. Further bytes are taken over a valid/ready handshake, and only during the final clock of the current byte. If no byte is offered in that clock, the encoder ends the message. It holds the line low, with the driver still enabled, for two full bit periods. It then releases the driver and pulses `done_o`.

Top module: `peci_tx_encoder`

## Requirements
- R1: After reset and whenever idle, `bus_o` is 0, `bus_oe_o` is 0, `byte_ready_o` is 1 and `done_o` is 0.
- R2: In idle, a byte handshake with `start_i` high starts a message, and `bus_oe_o` and `bus_o` are 1 in the next cycle. A byte offered while `start_i` is low is discarded and the bus stays disabled and low.
- R3: Every bit period of P clocks begins with a rising edge of `bus_o`, so consecutive rising edges inside a message are exactly P clocks apart.
- R4: A one bit is high for floor(3P/4) clocks and a zero bit is high for floor(3P/10) clocks. The line is low for the rest of the period.
- R5: Bits of each byte are sent most significant first (bit 7 first, bit 0 last).
- R6: During a message, `byte_ready_o` is high only in the last clock of the last bit of a byte. A byte accepted there starts at once, with no gap. A message of N bytes therefore shows exactly N ready cycles while the driver is enabled.
- R7: After the last bit, `bus_o` stays low with `bus_oe_o` high for 2P clocks beyond the end of that bit. `bus_o` is never high while `bus_oe_o` is low.
- R8: `done_o` is a single-cycle pulse in the first cycle in which `bus_oe_o` is low again after a message.
- R9: P is captured when the message starts. Changes on `bit_period_i` during a message have no effect on it.
- R10: A programmed period below MIN_PERIOD (default 8) is raised to MIN_PERIOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Qualifies an idle-state byte as the first byte of a message |
| bit_period_i | input | PW | Bit period in clocks, captured at message start |
| byte_valid_i | input | 1 | A message byte is offered |
| byte_data_i | input | 8 | Offered message byte |
| byte_ready_o | output | 1 | The offered byte is taken at this clock edge |
| bus_o | output | 1 | Encoded line level |
| bus_oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | One-cycle pulse when the stop interval has ended |

## Verification
The hardest case to reach is the handoff in the single clock where one byte's last bit ends. There, the next byte must be taken and its first rising edge must follow without a gap. It gets hard because the bench does not know that clock without counting periods. The driver therefore keeps `byte_valid_i` high for the whole message and checks `byte_ready_o` a half cycle before each edge, so the handoff falls wherever the design places it. The monitor then rebuilds every period from the distance between rising edges and compares each high time with a queue of values computed from the bytes. Messages use periods that round differently, a period below the minimum, and a period input changed after the start.

// File: rtl/peci_tx_pkg.sv
package peci_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_STOP = 2'd2
    } tx_state_e;

    // high time of a one bit: three quarters of the period, rounded down
    function automatic int unsigned one_high(input int unsigned period);
        return (period * 3) / 4;
    endfunction

    // high time of a zero bit: three tenths of the period, rounded down
    function automatic int unsigned zero_high(input int unsigned period);
        return (period * 3) / 10;
    endfunction

endpackage

// File: rtl/peci_tx_timer.sv
module peci_tx_timer
    import peci_tx_pkg::*;
#(
    parameter int PW         = 16,
    parameter int MIN_PERIOD = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [PW-1:0] period_i,
    input  logic          run_i,
    output logic [PW-1:0] cnt_o,
    output logic [PW-1:0] thr_one_o,
    output logic [PW-1:0] thr_zero_o,
    output logic          last_o
);
    localparam logic [PW-1:0] MIN_P = PW'(MIN_PERIOD);

    logic [PW-1:0] period_q;
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] thr_one_q;
    logic [PW-1:0] thr_zero_q;
    logic [PW-1:0] period_eff;

    always_comb begin
        period_eff = (period_i < MIN_P) ? MIN_P : period_i;
    end

    assign last_o = (cnt_q == period_q - PW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q   <= MIN_P;
            cnt_q      <= '0;
            thr_one_q  <= PW'(one_high(MIN_PERIOD));
            thr_zero_q <= PW'(zero_high(MIN_PERIOD));
        end else if (load_i) begin
            period_q   <= period_eff;
            cnt_q      <= '0;
            thr_one_q  <= PW'(one_high(32'(period_eff)));
            thr_zero_q <= PW'(zero_high(32'(period_eff)));
        end else if (run_i) begin
            cnt_q <= last_o ? '0 : cnt_q + PW'(1);
        end
    end

    assign cnt_o      = cnt_q;
    assign thr_one_o  = thr_one_q;
    assign thr_zero_o = thr_zero_q;

endmodule

// File: rtl/peci_tx_shifter.sv
module peci_tx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              shift_i,
    output logic              cur_bit_o,
    output logic              last_bit_o
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            sreg_q <= data_i;
            idx_q  <= '0;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    assign cur_bit_o  = sreg_q[BYTE_W-1];
    assign last_bit_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/peci_tx_ctrl.sv
module peci_tx_ctrl
    import peci_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      byte_valid_i,
    input  logic      period_last_i,
    input  logic      last_bit_i,
    output tx_state_e state_o,
    output logic      ready_o,
    output logic      accept_o,
    output logic      load_timer_o,
    output logic      shift_o,
    output logic      done_o
);
    tx_state_e state_q, state_d;
    logic      stop_half_q, stop_half_d;
    logic      done_q, done_d;
    logic      byte_end;

    assign byte_end = (state_q == TX_SEND) && period_last_i && last_bit_i;

    always_comb begin
        ready_o      = (state_q == TX_IDLE) || byte_end;
        accept_o     = ready_o && byte_valid_i && ((state_q != TX_IDLE) || start_i);
        load_timer_o = (state_q == TX_IDLE) && accept_o;
        shift_o      = (state_q == TX_SEND) && period_last_i && !last_bit_i;
    end

    always_comb begin
        state_d     = state_q;
        stop_half_d = stop_half_q;
        done_d      = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (accept_o) state_d = TX_SEND;
            end
            TX_SEND: begin
                if (byte_end && !accept_o) begin
                    state_d     = TX_STOP;
                    stop_half_d = 1'b0;
                end
            end
            TX_STOP: begin
                if (period_last_i) begin
                    if (stop_half_q) begin
                        state_d = TX_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        stop_half_d = 1'b1;
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= TX_IDLE;
            stop_half_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            stop_half_q <= stop_half_d;
            done_q      <= done_d;
        end
    end

    assign state_o = state_q;
    assign done_o  = done_q;

endmodule

// File: rtl/peci_tx_encoder.sv
module peci_tx_encoder
    import peci_tx_pkg::*;
#(
    parameter int PW         = 16,
    parameter int MIN_PERIOD = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [PW-1:0] bit_period_i,
    input  logic          byte_valid_i,
    input  logic [7:0]    byte_data_i,
    output logic          byte_ready_o,
    output logic          bus_o,
    output logic          bus_oe_o,
    output logic          done_o
);
    localparam int BYTE_W = 8;

    tx_state_e     state;
    logic          accept, load_timer, shift, period_last, last_bit, cur_bit;
    logic [PW-1:0] cnt, thr_one, thr_zero, thr_sel;

    peci_tx_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .period_last_i(period_last),
        .last_bit_i   (last_bit),
        .state_o      (state),
        .ready_o      (byte_ready_o),
        .accept_o     (accept),
        .load_timer_o (load_timer),
        .shift_o      (shift),
        .done_o       (done_o)
    );

    peci_tx_timer #(
        .PW        (PW),
        .MIN_PERIOD(MIN_PERIOD)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_timer),
        .period_i  (bit_period_i),
        .run_i     (state != TX_IDLE),
        .cnt_o     (cnt),
        .thr_one_o (thr_one),
        .thr_zero_o(thr_zero),
        .last_o    (period_last)
    );

    peci_tx_shifter #(
        .BYTE_W(BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load_i    (accept),
        .data_i    (byte_data_i),
        .shift_i   (shift),
        .cur_bit_o (cur_bit),
        .last_bit_o(last_bit)
    );

    assign thr_sel  = cur_bit ? thr_one : thr_zero;
    assign bus_o    = (state == TX_SEND) && (cnt < thr_sel);
    assign bus_oe_o = (state != TX_IDLE);

endmodule

// File: rtl/peci_tx_checker.sv
module peci_tx_checker (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic byte_valid_i,
    input logic byte_ready_o,
    input logic bus_o,
    input logic bus_oe_o,
    input logic done_o
);
    // R7
    bus_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_o |-> bus_oe_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!bus_oe_o && $past(bus_oe_o)));

    // R1
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_o |-> byte_ready_o);

    // R2
    start_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_oe_o && start_i && byte_valid_i) |=> (bus_oe_o && bus_o));

    // R2
    no_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_oe_o && !start_i) |=> !bus_o);

endmodule

bind peci_tx_encoder peci_tx_checker u_chk (.*);

// File: tb/tb_peci_tx_encoder.sv
module tb_peci_tx_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int PW         = 16;
    localparam int MINP       = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [PW-1:0] bit_period_i = '0;
    logic          byte_valid_i = 1'b0;
    logic [7:0]    byte_data_i = '0;
    logic          byte_ready_o, bus_o, bus_oe_o, done_o;

    peci_tx_encoder #(.PW(PW), .MIN_PERIOD(MINP)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .bit_period_i(bit_period_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .byte_ready_o(byte_ready_o), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
        .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    int exp_period = MINP;
    int done_cnt = 0;
    int ready_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int high_for(input int p, input bit b);
        return b ? (p * 3) / 4 : (p * 3) / 10;
    endfunction

    // monitor: rebuilds each bit period from rising edges
    bit prev_bus = 1'b0;
    bit have_bit = 1'b0;
    int hcnt = 0;
    int lcnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_o && !bus_oe_o) chk(1'b0, "R7 bus high with driver off", 1, 0);
            if (bus_oe_o && byte_ready_o) ready_cnt++;
            if (done_o) begin
                if (have_bit) begin
                    int e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                    chk(hcnt == e, "R4/R5 last bit high time", hcnt, e);
                    chk(lcnt == (exp_period - hcnt) + 2 * exp_period,
                        "R7 low run through stop", lcnt, (exp_period - hcnt) + 2 * exp_period);
                end
                chk(exp_q.size() == 0, "R6 bits left unsent", exp_q.size(), 0);
                have_bit = 1'b0;
                done_cnt++;
            end
            if (bus_o) begin
                if (!prev_bus) begin
                    if (have_bit) begin
                        int e;
                        e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                        chk(hcnt == e, "R4/R5 bit high time", hcnt, e);
                        chk(hcnt + lcnt == exp_period, "R3/R9 bit period", hcnt + lcnt, exp_period);
                    end
                    have_bit = 1'b1;
                    hcnt = 1;
                    lcnt = 0;
                end else begin
                    hcnt++;
                end
            end else if (have_bit) begin
                lcnt++;
            end
            prev_bus = bus_o;
        end
    end

    // driver: queues expected high times, then feeds the bytes
    task automatic send_msg(input int prog_p, input int eff_p, input logic [7:0] msg[$]);
        int n = msg.size();
        int d0 = done_cnt;
        int i = 0;
        bit acc;
        exp_period = eff_p;
        foreach (msg[k]) for (int b = 7; b >= 0; b--) exp_q.push_back(high_for(eff_p, msg[k][b]));
        ready_cnt = 0;
        @(negedge clk);
        bit_period_i = PW'(prog_p);
        start_i = 1'b1;
        byte_valid_i = 1'b1;
        byte_data_i = msg[0];
        while (i < n) begin
            acc = byte_ready_o;
            @(posedge clk);
            @(negedge clk);
            if (acc) begin
                i++;
                start_i = 1'b0;
                bit_period_i = PW'(prog_p + 17);   // R9: must not take effect
                if (i < n) byte_data_i = msg[i];
                else byte_valid_i = 1'b0;
            end
        end
        while (done_cnt == d0) @(negedge clk);
        chk(ready_cnt == n, "R6 ready cycles per message", ready_cnt, n);
        @(negedge clk);
        chk(!done_o, "R8 done lasts one cycle", done_o, 0);
        chk(!bus_oe_o && !bus_o && byte_ready_o, "R1 idle after message",
            {bus_oe_o, bus_o, byte_ready_o}, 3'b001);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        logic [7:0] m[$];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_o && !bus_oe_o && byte_ready_o && !done_o, "R1 reset state",
            {bus_o, bus_oe_o, byte_ready_o, done_o}, 4'b0010);

        // R2: a byte without start is discarded
        byte_valid_i = 1'b1;
        byte_data_i = 8'hFF;
        bit_period_i = PW'(20);
        begin
            bit seen = 1'b0;
            repeat (6) begin
                @(negedge clk);
                if (bus_o || bus_oe_o) seen = 1'b1;
            end
            chk(!seen && done_cnt == 0, "R2 byte without start ignored", seen, 0);
        end
        byte_valid_i = 1'b0;
        @(negedge clk);

        m = '{8'hA5};             send_msg(20, 20, m);
        m = '{8'h3C, 8'hFF};      send_msg(40, 40, m);
        m = '{8'h00, 8'h81, 8'h7E}; send_msg(13, 13, m);
        m = '{8'hC3};             send_msg(3, MINP, m);   // R10 clamp
        m = '{8'h5A, 8'h01};      send_msg(10, 10, m);

        chk(done_cnt == 5, "R8 one done per message", done_cnt, 5);
        report();
    end

endmodule